// File: doc/BRIEF.md
# Serial-to-Parallel FFT Input Buffer

This block sits in front of a four-path pipelined FFT. It takes one complex sample per clock (12-bit I and 12-bit Q) and gathers a whole symbol of `LANES * DEPTH` samples. It then hands the symbol to the FFT as `LANES` samples per clock, one per lane, over `DEPTH` consecutive beats. Sample j of a symbol, counted from zero at the sample flagged as the start, goes to lane `j mod LANES` at row `j / LANES`. Every sample gains two copies of its sign bit on the way in, which gives the FFT stages headroom against overflow.

Storage is doubled, so one symbol can fill while the previous one drains. A downstream stall input pauses the readout. If input keeps arriving while both halves are occupied, it is discarded and a sticky overflow flag is raised.

Top module: `fft_s2p_buffer`

## Requirements
- R1: While reset is asserted, and directly after it, `out_valid`, `out_head` and `overflow` are 0.
- R2: Each 12-bit input component appears at the output as a 14-bit value: the original bits below two copies of its bit 11, so that the value keeps its sign. The limits 0x7FF and 0x800 come out as 0x07FF and 0x3800.
- R3: Sample j of a symbol (j = 0 at the head sample) appears at output beat j/4 in lane j mod 4. Lane k occupies bits [14k+13:14k] of `out_re` and `out_im`.
- R4: `out_head` is 1 on the first beat of each symbol and on no other beat. With no stall, a symbol's 8 beats (DEPTH) come on consecutive clocks.
- R5: When the read side is idle and not stalled, the first beat of a symbol appears at the outputs after the second rising edge that follows the edge capturing the symbol's last sample.
- R6: A sample with `in_head` high, arriving while a symbol is partly collected, restarts collection at index 0. The partial samples are never output.
- R7: A valid sample without `in_head` arriving when no symbol is partly collected is ignored.
- R8: A second symbol can be collected while the first is being output. Symbols are output whole and in arrival order.
- R9: While `out_stall` is high, no beat is issued. `out_valid` is 0 in the following cycle, and the readout resumes at the next unsent beat.
- R10: A sample that arrives when both symbol stores are full is dropped and sets `overflow`, which stays 1 until reset. Collection resumes at the next head sample once a store is free.
- R11: Cycles with `in_valid` low capture nothing, whatever `in_head` and the data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_head | input | 1 | Marks sample 0 of a symbol |
| in_re | input | SAMPLE_W | Real part, two's complement |
| in_im | input | SAMPLE_W | Imaginary part, two's complement |
| out_stall | input | 1 | Downstream pause of the readout |
| out_valid | output | 1 | A beat of LANES samples is on the outputs |
| out_head | output | 1 | First beat of a symbol |
| out_re | output | LANES*(SAMPLE_W+GUARD_W) | Real parts, lane k in slice k |
| out_im | output | LANES*(SAMPLE_W+GUARD_W) | Imaginary parts, lane k in slice k |
| overflow | output | 1 | Sticky flag: input was dropped |

## Verification
The assertions are evaluated on every cycle and cover four properties:
- a head beat always carries valid data and never repeats on the next beat;
- a stall always blanks the next beat;
- the guard bits of every issued sample agree with its sign;
- the reader only touches a full store, and the overflow flag never clears.

Some behaviour can only be shown by the bench scenarios:
- the lane and row placement of each sample;
- the exact latency;
- the discarding of partial and headless symbols;
- the ordering of back-to-back symbols;
- the fact that dropped input never reappears at the output.

// File: rtl/fftbuf_pkg.sv
package fftbuf_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fftbuf_sext.sv
module fftbuf_sext #(
   parameter int unsigned IN_W  = 12,
   parameter int unsigned EXT_W = 2
) (
   input  logic [IN_W-1:0]       din,
   output logic [IN_W+EXT_W-1:0] dout
);
   generate
      if (EXT_W == 0) begin : g_pass
         assign dout = din;
      end else begin : g_ext
         assign dout = {{EXT_W{din[IN_W-1]}}, din};
      end
   endgenerate
endmodule

// File: rtl/fftbuf_lane_mem.sv
module fftbuf_lane_mem #(
   parameter int unsigned WORD_W = 28,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int unsigned WORDS = 1 << ADDR_W;

   logic [WORD_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/fftbuf_ctrl.sv
module fftbuf_ctrl #(
   parameter int unsigned LANES = 4,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned LB = $clog2(LANES),
   localparam int unsigned AB = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_head,
   input  logic        out_stall,
   output logic        wr_en,
   output logic [LB-1:0] wr_lane,
   output logic [AB:0]   wr_addr,
   output logic        rd_en,
   output logic        rd_first,
   output logic [AB:0]   rd_addr,
   output logic        overflow
);
   localparam int unsigned IB = LB + AB;
   localparam logic [IB-1:0] LAST_IDX = IB'(LANES * DEPTH - 1);
   localparam logic [AB-1:0] LAST_PTR = AB'(DEPTH - 1);

   logic [IB-1:0] wr_idx, eff_idx;
   logic [AB-1:0] rd_ptr;
   logic [1:0]    bank_full;
   logic          wr_bank, rd_bank, rd_active;
   logic          take, blocked, wr_last, rd_done;

   always_comb begin
      take    = in_valid && (in_head || (wr_idx != '0));
      blocked = bank_full[wr_bank];
      eff_idx = in_head ? '0 : wr_idx;
      wr_en   = take && !blocked;
      wr_last = wr_en && (eff_idx == LAST_IDX);
      rd_en   = rd_active && !out_stall;
      rd_done = rd_en && (rd_ptr == LAST_PTR);
   end

   assign wr_lane  = eff_idx[LB-1:0];
   assign wr_addr  = {wr_bank, eff_idx[IB-1:LB]};
   assign rd_addr  = {rd_bank, rd_ptr};
   assign rd_first = (rd_ptr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         wr_bank   <= 1'b0;
         rd_bank   <= 1'b0;
         rd_active <= 1'b0;
         rd_ptr    <= '0;
         bank_full <= '0;
         overflow  <= 1'b0;
      end else begin
         if (wr_en) wr_idx <= wr_last ? '0 : eff_idx + 1'b1;
         if (wr_last) wr_bank <= ~wr_bank;
         if (take && blocked) overflow <= 1'b1;
         for (int b = 0; b < 2; b++) begin
            if (wr_last && (wr_bank == 1'(b))) bank_full[b] <= 1'b1;
            else if (rd_done && (rd_bank == 1'(b))) bank_full[b] <= 1'b0;
         end
         if (!rd_active) begin
            if (bank_full[rd_bank]) begin
               rd_active <= 1'b1;
               rd_ptr    <= '0;
            end
         end else if (!out_stall) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (rd_ptr == LAST_PTR) begin
               rd_active <= 1'b0;
               rd_bank   <= ~rd_bank;
            end
         end
      end
   end

   // R8: the reader only ever walks a store that holds a complete symbol
   a_r8_read_full_store: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |-> bank_full[rd_bank]);

   // R10: once raised, the drop flag never falls
   a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R10: a head arriving into an occupied store is reported
   a_r10_drop_reported: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_head && bank_full[wr_bank]) |=> overflow);
endmodule

// File: rtl/fft_s2p_buffer.sv
module fft_s2p_buffer import fftbuf_pkg::*; #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned GUARD_W  = 2,
   parameter int unsigned LANES    = 4,
   parameter int unsigned DEPTH    = 256
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_valid,
   input  logic                                   in_head,
   input  logic [SAMPLE_W-1:0]                    in_re,
   input  logic [SAMPLE_W-1:0]                    in_im,
   input  logic                                   out_stall,
   output logic                                   out_valid,
   output logic                                   out_head,
   output logic [LANES*(SAMPLE_W+GUARD_W)-1:0]    out_re,
   output logic [LANES*(SAMPLE_W+GUARD_W)-1:0]    out_im,
   output logic                                   overflow
);
   localparam int unsigned OUT_W  = SAMPLE_W + GUARD_W;
   localparam int unsigned LB     = $clog2(LANES);
   localparam int unsigned AB     = $clog2(DEPTH);
   localparam int unsigned WORD_W = 2 * OUT_W;

   generate
      if (LANES < 2 || !is_pow2(LANES)) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 2");
      end
      if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
   endgenerate

   logic [OUT_W-1:0] ext_re, ext_im;
   logic             wr_en, rd_en, rd_first;
   logic [LB-1:0]    wr_lane;
   logic [AB:0]      wr_addr, rd_addr;

   fftbuf_sext #(.IN_W(SAMPLE_W), .EXT_W(GUARD_W)) u_sext_re (.din(in_re), .dout(ext_re));
   fftbuf_sext #(.IN_W(SAMPLE_W), .EXT_W(GUARD_W)) u_sext_im (.din(in_im), .dout(ext_im));

   fftbuf_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_head  (in_head),
      .out_stall(out_stall),
      .wr_en    (wr_en),
      .wr_lane  (wr_lane),
      .wr_addr  (wr_addr),
      .rd_en    (rd_en),
      .rd_first (rd_first),
      .rd_addr  (rd_addr),
      .overflow (overflow)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic              lane_we;
      logic [WORD_W-1:0] lane_word;

      assign lane_we = wr_en && (wr_lane == LB'(g));

      fftbuf_lane_mem #(.WORD_W(WORD_W), .ADDR_W(AB + 1)) u_mem (
         .clk  (clk),
         .we   (lane_we),
         .waddr(wr_addr),
         .wdata({ext_im, ext_re}),
         .re   (rd_en),
         .raddr(rd_addr),
         .rdata(lane_word)
      );

      assign out_re[g*OUT_W +: OUT_W] = lane_word[OUT_W-1:0];
      assign out_im[g*OUT_W +: OUT_W] = lane_word[WORD_W-1:OUT_W];

      // R2: guard bits of every issued sample agree with its sign bit
      a_r2_guard_re: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ($countones(lane_word[OUT_W-1:SAMPLE_W-1]) == 0 ||
                        $countones(lane_word[OUT_W-1:SAMPLE_W-1]) == GUARD_W + 1));
      a_r2_guard_im: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ($countones(lane_word[WORD_W-1:OUT_W+SAMPLE_W-1]) == 0 ||
                        $countones(lane_word[WORD_W-1:OUT_W+SAMPLE_W-1]) == GUARD_W + 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_head  <= 1'b0;
      end else begin
         out_valid <= rd_en;
         out_head  <= rd_en && rd_first;
      end
   end

   // R4: a head beat always carries data
   a_r4_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_head |-> out_valid);

   // R4: two heads never arrive on adjacent beats
   a_r4_head_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_head |=> !out_head);

   // R9: a stall blanks the following beat
   a_r9_stall_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      out_stall |=> !out_valid);
endmodule

// File: tb/fft_s2p_buffer_test.sv
module fft_s2p_buffer_test;
   localparam int L  = 4;
   localparam int D  = 8;
   localparam int SW = 12;
   localparam int GW = 2;
   localparam int OW = SW + GW;
   localparam int N  = L * D;
   localparam int VW = L * OW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_head = 1'b0, out_stall = 1'b0;
   logic [SW-1:0] in_re = '0, in_im = '0;
   logic out_valid, out_head, overflow;
   logic [VW-1:0] out_re, out_im;

   fft_s2p_buffer #(.SAMPLE_W(SW), .GUARD_W(GW), .LANES(L), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
      .in_re(in_re), .in_im(in_im), .out_stall(out_stall),
      .out_valid(out_valid), .out_head(out_head),
      .out_re(out_re), .out_im(out_im), .overflow(overflow));

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [VW-1:0] log_re [256];
   logic [VW-1:0] log_im [256];
   bit            log_hd [256];
   int            log_cyc[256];
   int            nlog = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && nlog < 256) begin
         log_re[nlog]  = out_re;
         log_im[nlog]  = out_im;
         log_hd[nlog]  = out_head;
         log_cyc[nlog] = cyc;
         nlog = nlog + 1;
      end
   end

   int tests = 0, fails = 0, last_cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] samp(input int s, input int j, input bit q);
      if (j == 1) return q ? 12'h800 : 12'h7FF;
      if (j == 2) return q ? 12'h7FF : 12'h800;
      return 12'(s * 389 + j * 97 + (q ? 1500 : 0));
   endfunction

   function automatic logic [VW-1:0] exp_vec(input int s, input int b, input bit q);
      logic [VW-1:0] v;
      for (int k = 0; k < L; k++) begin
         int iv;
         iv = $signed(samp(s, b * L + k, q));
         v[k*OW +: OW] = OW'(iv);
      end
      return v;
   endfunction

   task automatic send_sym(input int s, input int n, input bit hd, input bit gaps);
      for (int j = 0; j < n; j++) begin
         if (gaps && (j % 3 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0; in_head = 1'b1; in_re = 12'hA5A; in_im = 12'h5A5;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_head  = hd && (j == 0);
         in_re    = samp(s, j, 0);
         in_im    = samp(s, j, 1);
         last_cyc = cyc;
      end
      @(negedge clk);
      in_valid = 1'b0; in_head = 1'b0;
   endtask

   task automatic drain(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_syms(input int s0, input int s1, input int nsym, input string tag);
      chk(nlog == nsym * D, {tag, " beat count"}, 64'(nlog), 64'(nsym * D));
      for (int i = 0; i < nsym; i++) begin
         for (int b = 0; b < D; b++) begin
            int idx, s;
            idx = i * D + b;
            s = (i == 0) ? s0 : s1;
            chk(log_re[idx] == exp_vec(s, b, 0), {tag, " re"}, 64'(log_re[idx]), 64'(exp_vec(s, b, 0)));
            chk(log_im[idx] == exp_vec(s, b, 1), {tag, " im"}, 64'(log_im[idx]), 64'(exp_vec(s, b, 1)));
            chk(log_hd[idx] == (b == 0), "R4 head", 64'(log_hd[idx]), 64'(b == 0));
         end
      end
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 0 && out_head == 0 && overflow == 0, "R1 in reset",
          64'({out_valid, out_head, overflow}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 0 && out_head == 0 && overflow == 0, "R1 after reset",
          64'({out_valid, out_head, overflow}), 64'(0));

      // R2 R3 R5 R4: plain symbol, placement, extension, latency, contiguity
      nlog = 0;
      send_sym(1, N, 1, 0);
      drain(3 * D);
      check_syms(1, 0, 1, "R2 R3");
      chk(log_cyc[0] == last_cyc + 3, "R5 latency", 64'(log_cyc[0]), 64'(last_cyc + 3));
      for (int b = 1; b < D; b++)
         chk(log_cyc[b] == log_cyc[b-1] + 1, "R4 consecutive", 64'(log_cyc[b]), 64'(log_cyc[b-1] + 1));

      // R11: idle cycles with garbage and a stray head capture nothing
      nlog = 0;
      send_sym(2, N, 1, 1);
      drain(3 * D);
      check_syms(2, 0, 1, "R11");

      // R7: headless samples while idle are ignored
      nlog = 0;
      send_sym(3, 5, 0, 0);
      drain(20);
      chk(nlog == 0, "R7 no output", 64'(nlog), 64'(0));
      send_sym(4, N, 1, 0);
      drain(3 * D);
      check_syms(4, 0, 1, "R7");

      // R6: head mid-symbol restarts collection
      nlog = 0;
      send_sym(5, 10, 1, 0);
      send_sym(6, N, 1, 0);
      drain(3 * D);
      check_syms(6, 0, 1, "R6");

      // R8: back-to-back symbols
      nlog = 0;
      send_sym(7, N, 1, 0);
      send_sym(8, N, 1, 0);
      drain(3 * D);
      check_syms(7, 8, 2, "R8");

      // R9: stall in the middle of a readout
      nlog = 0;
      send_sym(9, N, 1, 0);
      while (nlog < 2) @(negedge clk);
      out_stall = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         chk(out_valid == 0, "R9 stalled", 64'(out_valid), 64'(0));
         @(negedge clk);
      end
      out_stall = 1'b0;
      drain(3 * D);
      check_syms(9, 0, 1, "R9");

      // R10: both stores occupied, third symbol dropped
      nlog = 0;
      out_stall = 1'b1;
      send_sym(10, N, 1, 0);
      send_sym(11, N, 1, 0);
      chk(overflow == 0, "R10 before drop", 64'(overflow), 64'(0));
      send_sym(12, N, 1, 0);
      chk(overflow == 1, "R10 flag", 64'(overflow), 64'(1));
      chk(nlog == 0, "R9 held output", 64'(nlog), 64'(0));
      out_stall = 1'b0;
      drain(4 * D);
      check_syms(10, 11, 2, "R10");
      nlog = 0;
      send_sym(13, N, 1, 0);
      drain(3 * D);
      check_syms(13, 0, 1, "R10 resume");
      chk(overflow == 1, "R10 sticky", 64'(overflow), 64'(1));

      summary();
   end
endmodule